// File: doc/BRIEF.md
# DMA Channel Interrupt Status Unit

This block gathers completion (terminal-count) and fault (error) events from a set of DMA channels and turns them into software-visible status plus a single interrupt line. Each channel raises a one-cycle pulse on its completion or fault input. The pulse sets a sticky raw bit for that event type. Software chooses which channels may interrupt by using two independent enable registers, one for completion and one for faults. It reads raw and enabled (masked) views of each event type, together with a summary that merges the two masked views per channel. It acknowledges events by writing ones to a dedicated clear register for each event type.

An interrupt handler normally reads the summary or the priority-index register first. That register names the lowest-numbered channel with a pending masked event, which is the channel to serve first. The handler then inspects the per-type masked views and clears what it has handled. Register accesses use a flat word-addressed bus. Reads return data one clock after the address is presented.

Top module: `dmairq_status`

## Requirements
- R1: A completion or fault pulse on channel c sets raw bit c of that event type at the next clock edge, whatever the enables are. Completion raw is readable at address 1 and fault raw at address 3, with bit c for channel c.
- R2: The masked completion view (address 2) is completion raw ANDed with the completion enable register (address 7). The masked fault view (address 4) is fault raw ANDed with the fault enable register (address 8).
- R3: The two enable registers are independent. Writing one never changes the masked view of the other event type. Both reset to 0.
- R4: The summary register (address 0) has bit c set exactly when masked completion bit c or masked fault bit c is set.
- R5: The irq output is registered. It is high one cycle after any summary bit is set, and low one cycle after all summary bits are clear.
- R6: Writing a 1 to bit c of the completion clear register (address 5) clears only completion raw bit c. Address 6 does the same for fault raw bits. Clear registers read as 0.
- R7: A 0 in a clear-register bit leaves that status bit unchanged.
- R8: When an event pulse and a clear of the same bit occur in the same cycle, the bit ends up set.
- R9: Addresses 0 to 4 are read-only. Writes to them change no register.
- R10: The register at address 9 returns, in bits [2:0], the index of the lowest-numbered channel whose summary bit is set, and bit 31 is 1 when any summary bit is set. When no summary bit is set it reads as 0.
- R11: After reset, all status, enable and index registers read 0 and irq is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| tc_evt_i | input | NUM_CH | Per-channel completion event pulses |
| err_evt_i | input | NUM_CH | Per-channel fault event pulses |
| addr_i | input | ADDR_W | Register word address |
| wr_en_i | input | 1 | Write strobe |
| wr_data_i | input | DATA_W | Write data |
| rd_data_o | output | DATA_W | Registered read data for the previous cycle's address |
| irq_o | output | 1 | Registered combined interrupt |

## Verification
A raw bit stuck at the wrong value shows up in the raw read one cycle after the read address is presented. It also shows up in the summary and irq within two cycles of the event or clear, provided the matching enable is set. A wrong enable or a crossed mask shows as a masked view that differs from raw AND enable on the next read. A lost event/clear priority shows as a cleared bit right after a collision cycle. Scan-order faults show in the priority-index register as soon as two channels are pending together.

// File: rtl/dmairq_pkg.sv
package dmairq_pkg;
  localparam int OFF_SUMMARY  = 0;
  localparam int OFF_TC_RAW   = 1;
  localparam int OFF_TC_MSK   = 2;
  localparam int OFF_ERR_RAW  = 3;
  localparam int OFF_ERR_MSK  = 4;
  localparam int OFF_TC_CLR   = 5;
  localparam int OFF_ERR_CLR  = 6;
  localparam int OFF_TC_EN    = 7;
  localparam int OFF_ERR_EN   = 8;
  localparam int OFF_PRIO     = 9;

  typedef enum logic [0:0] {
    EVT_TC  = 1'b0,
    EVT_ERR = 1'b1
  } evt_kind_e;
endpackage

// File: rtl/dmairq_evt_bank.sv
// Sticky per-channel event status for one event type; events win over clears.
module dmairq_evt_bank #(
  parameter int NUM_CH = 8
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic [NUM_CH-1:0] evt_i,
  input  logic              clr_we_i,
  input  logic [NUM_CH-1:0] clr_bits_i,
  input  logic [NUM_CH-1:0] enable_i,
  output logic [NUM_CH-1:0] raw_o,
  output logic [NUM_CH-1:0] masked_o
);
  logic [NUM_CH-1:0] raw_q;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic clr_c;
    assign clr_c = clr_we_i & clr_bits_i[c];
    always_ff @(posedge clk_i) begin
      if (rst_i)          raw_q[c] <= 1'b0;
      else if (evt_i[c])  raw_q[c] <= 1'b1;
      else if (clr_c)     raw_q[c] <= 1'b0;
    end
  end

  assign raw_o    = raw_q;
  assign masked_o = raw_q & enable_i;
endmodule

// File: rtl/dmairq_cfg_reg.sv
// Plain read/write configuration register with synchronous reset.
module dmairq_cfg_reg #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  logic         we_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i) begin
    if (rst_i)     q_o <= '0;
    else if (we_i) q_o <= d_i;
  end
endmodule

// File: rtl/dmairq_prio_enc.sv
// Finds the lowest-numbered set bit.
module dmairq_prio_enc #(
  parameter int NUM_CH = 8,
  localparam int IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic [NUM_CH-1:0] req_i,
  output logic [IDX_W-1:0]  idx_o,
  output logic              any_o
);
  always_comb begin
    idx_o = '0;
    for (int c = NUM_CH - 1; c >= 0; c--) begin
      if (req_i[c]) idx_o = IDX_W'(c);
    end
  end
  assign any_o = |req_i;
endmodule

// File: rtl/dmairq_status.sv
module dmairq_status #(
  parameter int NUM_CH = 8,
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32,
  localparam int IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic [NUM_CH-1:0] tc_evt_i,
  input  logic [NUM_CH-1:0] err_evt_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              irq_o
);
  import dmairq_pkg::*;

  logic [NUM_CH-1:0] tc_raw_q, err_raw_q, tc_msk, err_msk, summary;
  logic [NUM_CH-1:0] tc_en_q, err_en_q;
  logic [NUM_CH-1:0] wr_bits;
  logic              we_tc_clr, we_err_clr, we_tc_en, we_err_en;
  logic [IDX_W-1:0]  prio_idx;
  logic              prio_any;
  logic [DATA_W-1:0] rd_next;

  assign wr_bits    = wr_data_i[NUM_CH-1:0];
  assign we_tc_clr  = wr_en_i && (addr_i == ADDR_W'(OFF_TC_CLR));
  assign we_err_clr = wr_en_i && (addr_i == ADDR_W'(OFF_ERR_CLR));
  assign we_tc_en   = wr_en_i && (addr_i == ADDR_W'(OFF_TC_EN));
  assign we_err_en  = wr_en_i && (addr_i == ADDR_W'(OFF_ERR_EN));

  dmairq_cfg_reg #(.W(NUM_CH)) u_tc_en (
    .clk_i(clk_i), .rst_i(rst_i), .we_i(we_tc_en), .d_i(wr_bits), .q_o(tc_en_q));
  dmairq_cfg_reg #(.W(NUM_CH)) u_err_en (
    .clk_i(clk_i), .rst_i(rst_i), .we_i(we_err_en), .d_i(wr_bits), .q_o(err_en_q));

  dmairq_evt_bank #(.NUM_CH(NUM_CH)) u_tc_bank (
    .clk_i(clk_i), .rst_i(rst_i), .evt_i(tc_evt_i), .clr_we_i(we_tc_clr),
    .clr_bits_i(wr_bits), .enable_i(tc_en_q), .raw_o(tc_raw_q), .masked_o(tc_msk));
  dmairq_evt_bank #(.NUM_CH(NUM_CH)) u_err_bank (
    .clk_i(clk_i), .rst_i(rst_i), .evt_i(err_evt_i), .clr_we_i(we_err_clr),
    .clr_bits_i(wr_bits), .enable_i(err_en_q), .raw_o(err_raw_q), .masked_o(err_msk));

  assign summary = tc_msk | err_msk;

  dmairq_prio_enc #(.NUM_CH(NUM_CH)) u_prio (
    .req_i(summary), .idx_o(prio_idx), .any_o(prio_any));

  always_comb begin
    rd_next = '0;
    case (int'(addr_i))
      OFF_SUMMARY: rd_next[NUM_CH-1:0] = summary;
      OFF_TC_RAW:  rd_next[NUM_CH-1:0] = tc_raw_q;
      OFF_TC_MSK:  rd_next[NUM_CH-1:0] = tc_msk;
      OFF_ERR_RAW: rd_next[NUM_CH-1:0] = err_raw_q;
      OFF_ERR_MSK: rd_next[NUM_CH-1:0] = err_msk;
      OFF_TC_EN:   rd_next[NUM_CH-1:0] = tc_en_q;
      OFF_ERR_EN:  rd_next[NUM_CH-1:0] = err_en_q;
      OFF_PRIO: begin
        rd_next[IDX_W-1:0]  = prio_idx;
        rd_next[DATA_W-1]   = prio_any;
      end
      default:     rd_next = '0;
    endcase
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      rd_data_o <= '0;
      irq_o     <= 1'b0;
    end else begin
      rd_data_o <= rd_next;
      irq_o     <= |summary;
    end
  end
endmodule

// File: rtl/dmairq_status_chk.sv
module dmairq_status_chk #(
  parameter int NUM_CH = 8,
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_i,
  input logic [NUM_CH-1:0] tc_evt_i,
  input logic [NUM_CH-1:0] err_evt_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic              wr_en_i,
  input logic [DATA_W-1:0] wr_data_i,
  input logic [NUM_CH-1:0] tc_raw,
  input logic [NUM_CH-1:0] err_raw,
  input logic [NUM_CH-1:0] summary,
  input logic              irq_o
);
  import dmairq_pkg::*;
  logic tc_clr_w, err_clr_w;
  logic [NUM_CH-1:0] tc_clr_only, err_clr_only;
  assign tc_clr_w     = wr_en_i && (addr_i == ADDR_W'(OFF_TC_CLR));
  assign err_clr_w    = wr_en_i && (addr_i == ADDR_W'(OFF_ERR_CLR));
  assign tc_clr_only  = tc_clr_w  ? (wr_data_i[NUM_CH-1:0] & ~tc_evt_i)  : '0;
  assign err_clr_only = err_clr_w ? (wr_data_i[NUM_CH-1:0] & ~err_evt_i) : '0;

  assert_evt_sets_R8: assert property (@(posedge clk_i) disable iff (rst_i)
    (|tc_evt_i) |=> ((tc_raw & $past(tc_evt_i)) == $past(tc_evt_i)));
  assert_err_evt_sets_R1: assert property (@(posedge clk_i) disable iff (rst_i)
    (|err_evt_i) |=> ((err_raw & $past(err_evt_i)) == $past(err_evt_i)));
  assert_no_spurious_set_R1: assert property (@(posedge clk_i) disable iff (rst_i)
    1'b1 |=> ((tc_raw & ~$past(tc_raw) & ~$past(tc_evt_i)) == '0));
  assert_clear_works_R6: assert property (@(posedge clk_i) disable iff (rst_i)
    (|tc_clr_only) |=> ((tc_raw & $past(tc_clr_only)) == '0));
  assert_err_clear_works_R6: assert property (@(posedge clk_i) disable iff (rst_i)
    (|err_clr_only) |=> ((err_raw & $past(err_clr_only)) == '0));
  assert_irq_follows_R5: assert property (@(posedge clk_i) disable iff (rst_i)
    1'b1 |=> (irq_o == (|$past(summary))));
endmodule

bind dmairq_status dmairq_status_chk #(
  .NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
  .clk_i(clk_i), .rst_i(rst_i), .tc_evt_i(tc_evt_i), .err_evt_i(err_evt_i),
  .addr_i(addr_i), .wr_en_i(wr_en_i), .wr_data_i(wr_data_i),
  .tc_raw(tc_raw_q), .err_raw(err_raw_q), .summary(summary), .irq_o(irq_o)
);

// File: tb/dmairq_status_tb.sv
module dmairq_status_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_CH = 8;
  localparam int ADDR_W = 4;
  localparam int DATA_W = 32;

  logic              clk = 1'b0;
  logic              rst;
  logic [NUM_CH-1:0] tc_evt, err_evt;
  logic [ADDR_W-1:0] addr;
  logic              wr_en;
  logic [DATA_W-1:0] wr_data;
  logic [DATA_W-1:0] rd_data;
  logic              irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dmairq_status #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dut (
    .clk_i(clk), .rst_i(rst), .tc_evt_i(tc_evt), .err_evt_i(err_evt),
    .addr_i(addr), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .rd_data_o(rd_data), .irq_o(irq));

  task automatic check(string req, logic [DATA_W-1:0] act, logic [DATA_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  // One bus/event cycle, driven at the falling edge, released at the next falling edge.
  task automatic cycle(logic [NUM_CH-1:0] tc, logic [NUM_CH-1:0] er,
                       logic we, int a, logic [DATA_W-1:0] d);
    tc_evt = tc; err_evt = er; wr_en = we; addr = ADDR_W'(a); wr_data = d;
    @(negedge clk);
    tc_evt = '0; err_evt = '0; wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic wr(int a, logic [DATA_W-1:0] d);
    cycle('0, '0, 1'b1, a, d);
  endtask

  task automatic rd_check(string req, int a, logic [DATA_W-1:0] exp);
    addr = ADDR_W'(a);
    @(negedge clk);
    check(req, rd_data, exp);
  endtask

  task automatic t_reset();
    for (int a = 0; a < 10; a++) rd_check("R11 reset read", a, '0);
    check("R11 reset irq", {31'd0, irq}, 0);
  endtask

  task automatic t_raw_capture();
    cycle(8'h08, 8'h00, 1'b0, 0, '0);
    rd_check("R1 tc raw", 1, 32'h08);
    rd_check("R2 tc masked disabled", 2, 32'h00);
    rd_check("R4 summary disabled", 0, 32'h00);
    check("R5 irq stays low", {31'd0, irq}, 0);
  endtask

  task automatic t_enable_tc();
    wr(7, 32'h08);
    rd_check("R2 tc masked enabled", 2, 32'h08);
    rd_check("R4 summary tc", 0, 32'h08);
    check("R5 irq high", {31'd0, irq}, 1);
  endtask

  task automatic t_err_mask();
    cycle(8'h00, 8'h24, 1'b0, 0, '0);
    rd_check("R1 err raw", 3, 32'h24);
    rd_check("R3 err masked off while tc enabled", 4, 32'h00);
    wr(8, 32'h20);
    rd_check("R2 err masked", 4, 32'h20);
    rd_check("R3 tc masked untouched", 2, 32'h08);
    rd_check("R4 summary both", 0, 32'h28);
  endtask

  task automatic t_prio();
    rd_check("R10 lowest pending", 9, 32'h8000_0003);
    wr(7, 32'h00);
    rd_check("R10 next pending", 9, 32'h8000_0005);
    wr(7, 32'h08);
  endtask

  task automatic t_clear();
    cycle(8'h11, 8'h00, 1'b0, 0, '0);       // tc raw now 0x19
    wr(5, 32'h10);
    rd_check("R6 tc clear one bit", 1, 32'h09);
    rd_check("R6 err raw untouched by tc clear", 3, 32'h24);
    wr(6, 32'h04);
    rd_check("R6 err clear one bit", 3, 32'h20);
    wr(5, 32'h00);
    rd_check("R7 zero clear no effect", 1, 32'h09);
    rd_check("R6 clear reg reads 0", 5, 32'h00);
  endtask

  task automatic t_collision();
    cycle(8'h10, 8'h00, 1'b0, 0, '0);       // tc raw 0x19
    cycle(8'h01, 8'h00, 1'b1, 5, 32'h11);   // event ch0 with clear ch0,ch4
    rd_check("R8 event beats clear", 1, 32'h09);
  endtask

  task automatic t_readonly();
    for (int a = 0; a < 5; a++) wr(a, 32'hFF);
    rd_check("R9 tc raw after writes", 1, 32'h09);
    rd_check("R9 err raw after writes", 3, 32'h20);
    rd_check("R9 summary after writes", 0, 32'h28);
  endtask

  task automatic t_irq_fall();
    wr(5, 32'hFF);
    wr(6, 32'hFF);
    rd_check("R4 summary empty", 0, 32'h00);
    check("R5 irq low", {31'd0, irq}, 0);
    rd_check("R10 none pending", 9, 32'h00);
  endtask

  initial begin
    rst = 1'b1; tc_evt = '0; err_evt = '0; addr = '0; wr_en = 1'b0; wr_data = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_raw_capture();
    t_enable_tc();
    t_err_mask();
    t_prio();
    t_clear();
    t_collision();
    t_readonly();
    t_irq_fall();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule